// File: doc/BRIEF.md
# Beamformer Control and Interrupt Register Block

This block is the register front end of a multi-microphone beamforming engine. A simple 32-bit bus writes and reads four word registers:

- **Channel configuration** (offset 0x00): holds the per-channel enables, the selected target direction, the output gain and the source-mode bit.
- **Control** (offset 0x04): holds the direction-search enable, the stream-generation enable and three one-shot commands.
- **Interrupt status** (offset 0x08).
- **Interrupt mask** (offset 0x0C).

The block drives the stored fields as configuration outputs. The datapath side reports back through event inputs.

Every configuration and control field carries its own write-enable bit inside the same data word. Software can therefore change one field with a blind write, without a read-modify-write. Some state is also changed by hardware:

- The search enable and the channel enables are wiped when the search sample buffers report full.
- The path-reset and direction-update commands act for one cycle only.
- The two interrupt events latch into a write-one-to-clear status register. A mask selects which events reach the single registered interrupt line.

Top module: `bf_ctrl_regs`

## Requirements
- R1: After reset every output is 0, and every register reads 0.
- R2: In a write to offset 0x00, the fields update only when their own enable bit in the same word is 1:
  - channel enables `wrData[7:0]`, enabled by bit 28;
  - target direction `wrData[11:8]`, enabled by bit 29;
  - gain `wrData[22:12]`, enabled by bit 30;
  - source mode `wrData[24]`, enabled by bit 31.

  A field whose enable bit is 0 keeps its value.
- R3: Enable bits are not stored. Reading offset 0x00 returns the fields at the positions of R2, with bits 31:25 and bit 23 read as 0.
- R4: In a write to offset 0x04, search enable (bit 0) updates only when bit 8 is 1, and stream enable (bit 4) updates only when bit 10 is 1. Reading 0x04 returns them at bits 0 and 4, with all other bits 0.
- R5: A write to 0x04 with bits 1 and 9 set gives a one-cycle pulse on `searchRst` in the cycle after the write. Bits 5 and 11 do the same on `voiceRst`, and bits 6 and 12 on `dirUpdate`. These command bits always read as 0.
- R6: A cycle with `bufFull` high clears `searchEn` and all `chanEn` bits. This takes priority over a software write to those fields in the same cycle, and it leaves `streamEn` unchanged.
- R7: Status bit 0 is set by `dirRdyEvt` and status bit 1 by `vocRdyEvt`. Writing 1 to a status bit at offset 0x08 clears it, and writing 0 leaves it unchanged.
- R8: When an event and a write-one-to-clear of the same status bit fall in the same cycle, the bit ends up set.
- R9: The mask at 0x0C uses the same bit positions as the status register, and a mask bit of 1 blocks that source. `irq` is the OR of the unmasked status bits, registered, so it follows the status one cycle later.
- R10: A read returns its data on `rdData` one cycle after `rdEn`, and `rdData` holds between reads. Offsets outside 0x00 to 0x0C read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| bufFull | input | 1 | Search sample buffers full event |
| dirRdyEvt | input | 1 | Direction data ready event |
| vocRdyEvt | input | 1 | Voice buffer ready event |
| chanEn | output | 8 | Per-channel enables |
| targetDir | output | 4 | Selected output direction |
| gain | output | 11 | Output gain, unsigned 1.10 fixed point |
| srcMode | output | 1 | Source select: 0 raw buffer, 1 transformed data |
| searchEn | output | 1 | Direction search enable |
| streamEn | output | 1 | Voice stream enable |
| searchRst | output | 1 | One-cycle search path reset request |
| voiceRst | output | 1 | One-cycle voice path reset request |
| dirUpdate | output | 1 | One-cycle direction switch request |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with its default parameters:

- eight channels;
- a 4-bit direction;
- an 11-bit gain;
- two interrupt sources.

These fill the configuration word up to its enable bits, so every field edge and every reserved gap lies next to a live bit and can be probed. With only two status bits, a random phase hits the same-cycle collisions often:

- event against clear;
- buffer-full against a software enable.

A behavioural model is compared with every output on every clock throughout that phase.

// File: rtl/bf_ctrl_pkg.sv
package bf_ctrl_pkg;
  parameter int unsigned BUS_W   = 32;
  parameter int unsigned ADDR_W  = 8;
  parameter int unsigned NUM_CH  = 8;
  parameter int unsigned DIR_W   = 4;
  parameter int unsigned GAIN_W  = 11;
  parameter int unsigned NUM_IRQ = 2;

  // configuration word layout
  parameter int unsigned CH_LSB   = 0;
  parameter int unsigned DIR_LSB  = CH_LSB + NUM_CH;
  parameter int unsigned GAIN_LSB = DIR_LSB + DIR_W;
  parameter int unsigned SRC_BIT  = 24;
  parameter int unsigned WE_CH    = 28;
  parameter int unsigned WE_DIR   = 29;
  parameter int unsigned WE_GAIN  = 30;
  parameter int unsigned WE_SRC   = 31;

  // control word layout; enable of bit k of the list sits at CW_WE_LSB+k
  parameter int unsigned CW_SEARCH = 0;
  parameter int unsigned CW_SRST   = 1;
  parameter int unsigned CW_STREAM = 4;
  parameter int unsigned CW_VRST   = 5;
  parameter int unsigned CW_UPD    = 6;
  parameter int unsigned CW_WE_LSB = 8;

  parameter int unsigned OFS_CFG  = 'h0;
  parameter int unsigned OFS_CTL  = 'h4;
  parameter int unsigned OFS_STAT = 'h8;
  parameter int unsigned OFS_MASK = 'hC;

  typedef struct packed {
    logic cfgWr;
    logic ctlWr;
    logic statWr;
    logic maskWr;
    logic rdCfg;
    logic rdCtl;
    logic rdStat;
    logic rdMask;
    logic rdAny;
  } regStrobe_t;
endpackage

// File: rtl/bf_ctrl_decode.sv
module bf_ctrl_decode
  import bf_ctrl_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  output regStrobe_t    strobe
);
  localparam logic [AW-1:0] A_CFG  = AW'(OFS_CFG);
  localparam logic [AW-1:0] A_CTL  = AW'(OFS_CTL);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_MASK = AW'(OFS_MASK);

  logic hitCfg, hitCtl, hitStat, hitMask;

  always_comb begin
    hitCfg  = (addr == A_CFG);
    hitCtl  = (addr == A_CTL);
    hitStat = (addr == A_STAT);
    hitMask = (addr == A_MASK);

    strobe.cfgWr  = wrEn & hitCfg;
    strobe.ctlWr  = wrEn & hitCtl;
    strobe.statWr = wrEn & hitStat;
    strobe.maskWr = wrEn & hitMask;
    strobe.rdCfg  = rdEn & hitCfg;
    strobe.rdCtl  = rdEn & hitCtl;
    strobe.rdStat = rdEn & hitStat;
    strobe.rdMask = rdEn & hitMask;
    // an unmapped read still loads rdData, with zero
    strobe.rdAny  = rdEn;
  end
endmodule

// File: rtl/bf_ctrl_store.sv
module bf_ctrl_store
  import bf_ctrl_pkg::*;
#(
  parameter int unsigned DW   = BUS_W,
  parameter int unsigned NCH  = NUM_CH,
  parameter int unsigned DIRW = DIR_W,
  parameter int unsigned GW   = GAIN_W,
  parameter int unsigned NIRQ = NUM_IRQ
) (
  input  logic            clk,
  input  logic            rstN,
  input  regStrobe_t      strobe,
  input  logic [DW-1:0]   wrData,
  input  logic            bufFull,
  input  logic [NIRQ-1:0] irqEvt,
  output logic [NCH-1:0]  chanEn,
  output logic [DIRW-1:0] targetDir,
  output logic [GW-1:0]   gain,
  output logic            srcMode,
  output logic            searchEn,
  output logic            streamEn,
  output logic            searchRst,
  output logic            voiceRst,
  output logic            dirUpdate,
  output logic [NIRQ-1:0] statQ,
  output logic [NIRQ-1:0] maskQ,
  output logic            irq,
  output logic [DW-1:0]   rdData
);
  localparam int unsigned WE_SEARCH = CW_WE_LSB + 0;
  localparam int unsigned WE_SRST   = CW_WE_LSB + 1;
  localparam int unsigned WE_STREAM = CW_WE_LSB + 2;
  localparam int unsigned WE_VRST   = CW_WE_LSB + 3;
  localparam int unsigned WE_UPD    = CW_WE_LSB + 4;

  logic [DW-1:0] rdNext;

  // channel enables: software set/clear, hardware clear wins
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic chQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        chQ <= 1'b0;
      else if (bufFull)
        chQ <= 1'b0;
      else if (strobe.cfgWr && wrData[WE_CH])
        chQ <= wrData[CH_LSB + c];
    end
    assign chanEn[c] = chQ;
  end

  // remaining configuration fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetDir <= '0;
      gain      <= '0;
      srcMode   <= 1'b0;
    end else if (strobe.cfgWr) begin
      if (wrData[WE_DIR])  targetDir <= wrData[DIR_LSB +: DIRW];
      if (wrData[WE_GAIN]) gain      <= wrData[GAIN_LSB +: GW];
      if (wrData[WE_SRC])  srcMode   <= wrData[SRC_BIT];
    end
  end

  // control enables and one-shot commands
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      searchEn  <= 1'b0;
      streamEn  <= 1'b0;
      searchRst <= 1'b0;
      voiceRst  <= 1'b0;
      dirUpdate <= 1'b0;
    end else begin
      searchRst <= strobe.ctlWr & wrData[WE_SRST] & wrData[CW_SRST];
      voiceRst  <= strobe.ctlWr & wrData[WE_VRST] & wrData[CW_VRST];
      dirUpdate <= strobe.ctlWr & wrData[WE_UPD]  & wrData[CW_UPD];
      if (strobe.ctlWr && wrData[WE_STREAM])
        streamEn <= wrData[CW_STREAM];
      if (bufFull)
        searchEn <= 1'b0;
      else if (strobe.ctlWr && wrData[WE_SEARCH])
        searchEn <= wrData[CW_SEARCH];
    end
  end

  // interrupt status, event set beats write-one clear
  for (genvar i = 0; i < NIRQ; i++) begin : g_stat
    logic stQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stQ <= 1'b0;
      else if (irqEvt[i])
        stQ <= 1'b1;
      else if (strobe.statWr && wrData[i])
        stQ <= 1'b0;
    end
    assign statQ[i] = stQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      irq   <= 1'b0;
    end else begin
      if (strobe.maskWr) maskQ <= wrData[NIRQ-1:0];
      irq <= |(statQ & ~maskQ);
    end
  end

  // read mux and registered read data
  always_comb begin
    rdNext = '0;
    if (strobe.rdCfg) begin
      rdNext[CH_LSB +: NCH]    = chanEn;
      rdNext[DIR_LSB +: DIRW]  = targetDir;
      rdNext[GAIN_LSB +: GW]   = gain;
      rdNext[SRC_BIT]          = srcMode;
    end
    if (strobe.rdCtl) begin
      rdNext[CW_SEARCH] = searchEn;
      rdNext[CW_STREAM] = streamEn;
    end
    if (strobe.rdStat) rdNext[NIRQ-1:0] = statQ;
    if (strobe.rdMask) rdNext[NIRQ-1:0] = maskQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (strobe.rdAny)
      rdData <= rdNext;
  end
endmodule

// File: rtl/bf_ctrl_regs.sv
module bf_ctrl_regs
  import bf_ctrl_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = BUS_W,
  parameter int unsigned NCH  = NUM_CH,
  parameter int unsigned DIRW = DIR_W,
  parameter int unsigned GW   = GAIN_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            rdEn,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wrData,
  output logic [DW-1:0]   rdData,
  input  logic            bufFull,
  input  logic            dirRdyEvt,
  input  logic            vocRdyEvt,
  output logic [NCH-1:0]  chanEn,
  output logic [DIRW-1:0] targetDir,
  output logic [GW-1:0]   gain,
  output logic            srcMode,
  output logic            searchEn,
  output logic            streamEn,
  output logic            searchRst,
  output logic            voiceRst,
  output logic            dirUpdate,
  output logic            irq
);
  localparam int unsigned NIRQ = 2;

  regStrobe_t      strobe;
  logic [NIRQ-1:0] irqEvt;
  logic [NIRQ-1:0] statQ;
  logic [NIRQ-1:0] maskQ;

  assign irqEvt = {vocRdyEvt, dirRdyEvt};

  bf_ctrl_decode #(.AW(AW)) u_decode (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe)
  );

  bf_ctrl_store #(
    .DW(DW), .NCH(NCH), .DIRW(DIRW), .GW(GW), .NIRQ(NIRQ)
  ) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .bufFull   (bufFull),
    .irqEvt    (irqEvt),
    .chanEn    (chanEn),
    .targetDir (targetDir),
    .gain      (gain),
    .srcMode   (srcMode),
    .searchEn  (searchEn),
    .streamEn  (streamEn),
    .searchRst (searchRst),
    .voiceRst  (voiceRst),
    .dirUpdate (dirUpdate),
    .statQ     (statQ),
    .maskQ     (maskQ),
    .irq       (irq),
    .rdData    (rdData)
  );
endmodule

// File: rtl/bf_ctrl_regs_chk.sv
module bf_ctrl_regs_chk
  import bf_ctrl_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned NCH  = NUM_CH,
  parameter int unsigned DIRW = DIR_W
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [AW-1:0]   addr,
  input logic [31:0]     wrData,
  input logic [31:0]     rdData,
  input logic            bufFull,
  input logic            dirRdyEvt,
  input logic [NCH-1:0]  chanEn,
  input logic [DIRW-1:0] targetDir,
  input logic            searchEn,
  input logic            searchRst,
  input logic [1:0]      statQ,
  input logic [1:0]      maskQ,
  input logic            irq
);
  localparam logic [AW-1:0] A_CFG  = AW'(OFS_CFG);
  localparam logic [AW-1:0] A_CTL  = AW'(OFS_CTL);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);

  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn && addr == A_CFG && wrData[WE_DIR]) |-> $stable(targetDir));

  assert_rd_reserved_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31:25] == 7'd0);

  assert_search_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    searchRst |-> $past(wrEn && addr == A_CTL && wrData[CW_WE_LSB + 1] && wrData[CW_SRST]));

  assert_buf_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(bufFull) |-> (!searchEn && chanEn == '0));

  assert_w1c_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statQ[0]) && !$past(wrEn && addr == A_STAT && wrData[0])) |-> statQ[0]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(dirRdyEvt) |-> statQ[0]);

  assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(maskQ == 2'b11) |-> !irq);
endmodule

bind bf_ctrl_regs bf_ctrl_regs_chk #(.AW(AW), .NCH(NCH), .DIRW(DIRW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .rdData    (rdData),
  .bufFull   (bufFull),
  .dirRdyEvt (dirRdyEvt),
  .chanEn    (chanEn),
  .targetDir (targetDir),
  .searchEn  (searchEn),
  .searchRst (searchRst),
  .statQ     (statQ),
  .maskQ     (maskQ),
  .irq       (irq)
);

// File: tb/bf_ctrl_regs_tb.sv
module bf_ctrl_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        bufFull = 1'b0, dirRdyEvt = 1'b0, vocRdyEvt = 1'b0;
  logic [31:0] rdData;
  logic [7:0]  chanEn;
  logic [3:0]  targetDir;
  logic [10:0] gain;
  logic        srcMode, searchEn, streamEn, searchRst, voiceRst, dirUpdate, irq;

  int nChecks = 0;
  int nErr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bf_ctrl_regs u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .bufFull(bufFull),
    .dirRdyEvt(dirRdyEvt), .vocRdyEvt(vocRdyEvt), .chanEn(chanEn),
    .targetDir(targetDir), .gain(gain), .srcMode(srcMode),
    .searchEn(searchEn), .streamEn(streamEn), .searchRst(searchRst),
    .voiceRst(voiceRst), .dirUpdate(dirUpdate), .irq(irq)
  );

  // behavioural reference model
  logic [7:0]  mChan;
  logic [3:0]  mDir;
  logic [10:0] mGain;
  logic        mSrc, mSearch, mStream, mSr, mVr, mUd, mIrq;
  logic [1:0]  mStat, mMask;
  logic [31:0] mRd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mChan = 0; mDir = 0; mGain = 0; mSrc = 0; mSearch = 0; mStream = 0;
      mSr = 0; mVr = 0; mUd = 0; mIrq = 0; mStat = 0; mMask = 0; mRd = 0;
    end else begin
      if (rdEn) begin
        case (addr)
          8'h00:   mRd = {7'd0, mSrc, 1'b0, mGain, mDir, mChan};
          8'h04:   mRd = {27'd0, mStream, 3'd0, mSearch};
          8'h08:   mRd = {30'd0, mStat};
          8'h0C:   mRd = {30'd0, mMask};
          default: mRd = 32'd0;
        endcase
      end
      mIrq = |(mStat & ~mMask);
      mSr = 0; mVr = 0; mUd = 0;
      if (wrEn && addr == 8'h04) begin
        if (wrData[8])  mSearch = wrData[0];
        if (wrData[10]) mStream = wrData[4];
        mSr = wrData[9] & wrData[1];
        mVr = wrData[11] & wrData[5];
        mUd = wrData[12] & wrData[6];
      end
      if (wrEn && addr == 8'h00) begin
        if (wrData[28]) mChan = wrData[7:0];
        if (wrData[29]) mDir  = wrData[11:8];
        if (wrData[30]) mGain = wrData[22:12];
        if (wrData[31]) mSrc  = wrData[24];
      end
      if (wrEn && addr == 8'h0C) mMask = wrData[1:0];
      if (wrEn && addr == 8'h08) mStat = mStat & ~wrData[1:0];
      if (dirRdyEvt) mStat[0] = 1'b1;
      if (vocRdyEvt) mStat[1] = 1'b1;
      if (bufFull) begin mSearch = 0; mChan = 0; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 chanEn", 32'(chanEn), 32'(mChan));
      chk("R2 targetDir", 32'(targetDir), 32'(mDir));
      chk("R2 gain", 32'(gain), 32'(mGain));
      chk("R2 srcMode", 32'(srcMode), 32'(mSrc));
      chk("R4 searchEn", 32'(searchEn), 32'(mSearch));
      chk("R4 streamEn", 32'(streamEn), 32'(mStream));
      chk("R5 pulses", {29'd0, searchRst, voiceRst, dirUpdate}, {29'd0, mSr, mVr, mUd});
      chk("R9 irq", 32'(irq), 32'(mIrq));
      chk("R10 rdData", rdData, mRd);
    end
  end

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    @(posedge clk); #1;
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nErr++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle();
    // R1 reset state
    chk("R1 outputs", {chanEn, targetDir, gain, srcMode, searchEn, streamEn,
        searchRst, voiceRst, dirUpdate, irq}, 32'd0);
    busRd(8'h00, rv); chk("R1 cfg read", rv, 32'd0);
    busRd(8'h08, rv); chk("R1 status read", rv, 32'd0);

    // R2/R3 full write including reserved bits
    busWr(8'h00, 32'hFFDA_5AC3);
    busRd(8'h00, rv); chk("R3 cfg readback", rv, 32'h015A_5AC3);
    // R2 only direction enabled
    busWr(8'h00, 32'h207F_F5FF);
    busRd(8'h00, rv); chk("R2 partial write", rv, 32'h015A_55C3);

    // R4 enables
    busWr(8'h04, 32'h0000_0511);
    busRd(8'h04, rv); chk("R4 ctl set", rv, 32'h11);
    busWr(8'h04, 32'h0000_00EE);
    busRd(8'h04, rv); chk("R4 no enable no change", rv, 32'h11);

    // R5 one-shot commands
    busWr(8'h04, 32'h0000_1A62);
    chk("R5 pulse high", {29'd0, searchRst, voiceRst, dirUpdate}, 32'h7);
    idle();
    chk("R5 pulse gone", {29'd0, searchRst, voiceRst, dirUpdate}, 32'h0);
    busRd(8'h04, rv); chk("R5 command reads zero", rv, 32'h11);

    // R6 buffer full
    bufFull = 1'b1; idle(); bufFull = 1'b0;
    chk("R6 cleared", {22'd0, chanEn, searchEn, streamEn}, 32'h1);
    bufFull = 1'b1;
    busWr(8'h00, 32'h1000_000F);
    bufFull = 1'b0;
    chk("R6 hw clear wins", 32'(chanEn), 32'h0);

    // R7 status set and clear
    dirRdyEvt = 1'b1; idle(); dirRdyEvt = 1'b0;
    idle();
    chk("R9 irq raised", 32'(irq), 32'h1);
    busWr(8'h08, 32'h2);
    busRd(8'h08, rv); chk("R7 write of other bit", rv, 32'h1);
    busWr(8'h08, 32'h1);
    busRd(8'h08, rv); chk("R7 cleared", rv, 32'h0);
    chk("R9 irq dropped", 32'(irq), 32'h0);

    // R8 set beats clear
    dirRdyEvt = 1'b1;
    busWr(8'h08, 32'h1);
    dirRdyEvt = 1'b0;
    busRd(8'h08, rv); chk("R8 set wins", rv, 32'h1);

    // R9 masking
    busWr(8'h0C, 32'h1);
    idle(); idle();
    chk("R9 masked", 32'(irq), 32'h0);
    busRd(8'h0C, rv); chk("R9 mask readback", rv, 32'h1);
    vocRdyEvt = 1'b1; idle(); vocRdyEvt = 1'b0;
    idle();
    chk("R9 unmasked source", 32'(irq), 32'h1);
    busRd(8'h08, rv); chk("R7 both set", rv, 32'h3);

    // R10 unmapped offset
    busWr(8'h10, 32'hFFFF_FFFF);
    busRd(8'h10, rv); chk("R10 unmapped read", rv, 32'h0);
    busRd(8'h00, rv); chk("R10 unmapped write ignored", rv, 32'h015A_5500);

    // random phase, model compared every clock
    for (int i = 0; i < 600; i++) begin
      logic [2:0] sel;
      sel = 3'($urandom_range(0, 4));
      addr = (sel == 3'd4) ? 8'h10 : {3'd0, sel, 2'b00};
      wrEn = ($urandom_range(0, 2) == 0);
      rdEn = ($urandom_range(0, 2) == 0);
      wrData = $urandom();
      bufFull = ($urandom_range(0, 9) == 0);
      dirRdyEvt = ($urandom_range(0, 5) == 0);
      vocRdyEvt = ($urandom_range(0, 5) == 0);
      idle();
    end
    wrEn = 0; rdEn = 0; bufFull = 0; dirRdyEvt = 0; vocRdyEvt = 0;
    idle(); idle();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule